// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target side of a two-wire serial bus. It runs on the system clock and oversamples the bus clock and data lines, which it brings in through a small synchronizer. It finds START and STOP conditions, matches a 7-bit address against a value supplied by the host, and then either takes bytes from the bus controller or sends bytes to it. It drives both bus lines only by pulling them low. Each output is an enable that means "pull low", and the board pull-ups supply the high level.

Host logic on the chip sees a one-byte buffer with a full flag, an overflow flag, the direction bit of the last matched address and a sticky per-byte interrupt flag. It controls the block through a stretch-enable level and single-cycle strobes: one to release the clock, one to read the buffer, one to load transmit data, and one each to clear the overflow and interrupt flags. While the block holds the clock low, the bus controller waits. This gives the host time to consume a received byte or to prepare the next byte to send.

Top module: `i2c_tgt`

## Requirements
- R1: An address byte whose upper seven bits equal `own_addr` and whose bit 0 is 0 is acknowledged (SDA pulled low during the ninth clock). `rw_stat` becomes 0, `rx_byte` takes the whole address byte and `buf_full` becomes 1.
- R2: A matching address byte with bit 0 equal to 1 is acknowledged. `rw_stat` becomes 1 and `rx_byte` takes the address byte. SCL is then held low even when `stretch_en` is 0, until `clk_release` is pulsed.
- R3: A byte that ends while `buf_full` or `ovf` is set gets no acknowledge, and `rx_byte` is left unchanged. `ovf` is set. The engine then ignores the bus until the next START.
- R4: `irq` rises after the falling edge of the ninth clock of every byte handled with a matching address, including the address byte. It stays set until `irq_clr` is pulsed.
- R5: In receive mode with `stretch_en` at 1, SCL is held low after each byte until `clk_release` is pulsed. With `stretch_en` at 0, the block does not hold SCL after a received byte.
- R6: Bytes loaded through `tx_wr` are sent MSB first. SDA changes only while SCL is low.
- R7: The controller's ninth bit is sampled on the ninth rising edge. An acknowledge (low) makes the block hold SCL for the next byte. A not-acknowledge (high) clears `rw_stat`, releases both lines and leaves the engine idle until a START, so later bytes are not acknowledged.
- R8: START (SDA falls while SCL is high) restarts address reception from any point, including the middle of a byte. STOP (SDA rises while SCL is high) returns the engine to idle, and bytes clocked after it are not acknowledged.
- R9: An address that does not match gets no acknowledge, leaves `irq` and `buf_full` unchanged, and leaves the engine idle.
- R10: Pulsing `buf_rd` clears `buf_full`, and pulsing `ovf_clr` clears `ovf`.
- R11: After reset, `scl_oe`, `sda_oe`, `irq`, `buf_full`, `ovf` and `rw_stat` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| scl_oe | output | 1 | Pull bus clock low (clock stretch) |
| sda_oe | output | 1 | Pull bus data low |
| own_addr | input | 7 | Target address to match |
| stretch_en | input | 1 | Hold SCL after each received byte |
| clk_release | input | 1 | Strobe: let go of a stretched SCL |
| buf_rd | input | 1 | Strobe: host has read the buffer, clears full |
| tx_wr | input | 1 | Strobe: load `tx_data` for transmission |
| tx_data | input | 8 | Next byte to send |
| ovf_clr | input | 1 | Strobe: clear overflow flag |
| irq_clr | input | 1 | Strobe: clear interrupt flag |
| rx_byte | output | 8 | Byte buffer (last accepted byte) |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was busy |
| rw_stat | output | 1 | Direction bit of the last matched address |
| irq | output | 1 | Sticky per-byte interrupt flag |

## Verification
The assertions check four rules on every cycle. The interrupt flag stays set until it is cleared. A stretch lasts until the release strobe or a bus condition ends it. The buffer never changes while it holds an unread byte. The data output never moves while the synchronized clock is high, except right after START or STOP. The directed scenarios are the only way to show the bus-level outcomes. These are whether each byte was acknowledged, the exact bits a controller reads back, the forced stretch after a read address, the return to idle after a not-acknowledge or STOP, and the restart when START arrives in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_TX
    } tgt_state_e;

    // synchronized line levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return b[BYTE_W-1:1] == a;
    endfunction

endpackage

// File: rtl/i2c_tgt_lines.sv
module i2c_tgt_lines
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_q[STAGES-1];
        ev.sda   = sda_q[STAGES-1];
        ev.rise  = ev.scl & ~scl_d;
        ev.fall  = ~ev.scl & scl_d;
        ev.start = ev.scl & scl_d & sda_d & ~ev.sda;
        ev.stop  = ev.scl & scl_d & ~sda_d & ev.sda;
    end

    // R8: a START needs the data line high in the cycle before
    a_r8_start_from_high: assert property (@(posedge clk) disable iff (rst)
        ev.start |-> $past(ev.sda));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              clk_release,
    input  logic              buf_rd,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              buf_full,
    output logic              ovf,
    output logic              rw_stat,
    output logic              irq
);

    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    tgt_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh, rx_q;
    logic full_q, ovf_q, rw_q, irq_q, ack_drv, acked, mack, stretch;
    logic busy;

    assign busy = full_q | ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            rx_q    <= '0;
            full_q  <= 1'b0;
            ovf_q   <= 1'b0;
            rw_q    <= 1'b0;
            irq_q   <= 1'b0;
            ack_drv <= 1'b0;
            acked   <= 1'b0;
            mack    <= 1'b0;
            stretch <= 1'b0;
        end else begin
            if (buf_rd)      full_q  <= 1'b0;
            if (ovf_clr)     ovf_q   <= 1'b0;
            if (irq_clr)     irq_q   <= 1'b0;
            if (clk_release) stretch <= 1'b0;
            if (tx_wr && state == ST_TX) sh <= tx_data;

            if (ev.start) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                ack_drv <= 1'b0;
                stretch <= 1'b0;
            end else if (ev.stop) begin
                state   <= ST_IDLE;
                cnt     <= '0;
                ack_drv <= 1'b0;
                stretch <= 1'b0;
            end else if (ev.rise) begin
                if (state == ST_ADDR || state == ST_RX) begin
                    if (cnt < LAST_BIT) sh <= {sh[BYTE_W-2:0], ev.sda};
                    cnt <= cnt + 1'b1;
                end else if (state == ST_TX && cnt == LAST_BIT) begin
                    mack <= ev.sda;
                end
            end else if (ev.fall) begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (cnt == LAST_BIT) begin
                            if (state == ST_ADDR && !addr_hit(sh, own_addr)) begin
                                state <= ST_IDLE;
                            end else begin
                                if (state == ST_ADDR) rw_q <= sh[0];
                                acked <= ~busy;
                                if (busy) begin
                                    ovf_q <= 1'b1;
                                end else begin
                                    rx_q    <= sh;
                                    full_q  <= 1'b1;
                                    ack_drv <= 1'b1;
                                end
                            end
                        end else if (cnt == ACK_BIT) begin
                            ack_drv <= 1'b0;
                            cnt     <= '0;
                            irq_q   <= 1'b1;
                            if (!acked) begin
                                state <= ST_IDLE;
                            end else if (state == ST_ADDR) begin
                                state   <= rw_q ? ST_TX : ST_RX;
                                stretch <= rw_q | stretch_en;
                            end else begin
                                stretch <= stretch_en;
                            end
                        end
                    end
                    ST_TX: begin
                        if (cnt == LAST_BIT) begin
                            cnt   <= '0;
                            irq_q <= 1'b1;
                            if (mack) begin
                                state <= ST_IDLE;
                                rw_q  <= 1'b0;
                            end else begin
                                stretch <= 1'b1;
                            end
                        end else begin
                            if (cnt < LAST_BIT - 1'b1) sh <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe   = ack_drv | (state == ST_TX && cnt < LAST_BIT && !sh[BYTE_W-1]);
    assign scl_oe   = stretch;
    assign rx_byte  = rx_q;
    assign buf_full = full_q;
    assign ovf      = ovf_q;
    assign rw_stat  = rw_q;
    assign irq      = irq_q;

    // R4: the interrupt flag is sticky until the host clears it
    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_q && !irq_clr |=> irq_q);

    // R5 / R2: a stretch lasts until release or a bus condition
    a_r5_stretch_hold: assert property (@(posedge clk) disable iff (rst)
        stretch && !clk_release && !ev.start && !ev.stop |=> stretch);

    // R3: an unread buffer is never overwritten
    a_r3_buf_frozen: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_q) |-> !$past(full_q));

    // R6: data output only moves while the synchronized clock is low
    a_r6_sda_low_phase: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) && !$past(ev.start) && !$past(ev.stop) |-> !$past(ev.scl));

endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic [6:0]  own_addr,
    input  logic        stretch_en,
    input  logic        clk_release,
    input  logic        buf_rd,
    input  logic        tx_wr,
    input  logic [7:0]  tx_data,
    input  logic        ovf_clr,
    input  logic        irq_clr,
    output logic [7:0]  rx_byte,
    output logic        buf_full,
    output logic        ovf,
    output logic        rw_stat,
    output logic        irq
);

    line_ev_t ev;

    i2c_tgt_lines #(.STAGES(SYNC_STAGES)) u_lines (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .own_addr    (own_addr),
        .stretch_en  (stretch_en),
        .clk_release (clk_release),
        .buf_rd      (buf_rd),
        .tx_wr       (tx_wr),
        .tx_data     (tx_data),
        .ovf_clr     (ovf_clr),
        .irq_clr     (irq_clr),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .rx_byte     (rx_byte),
        .buf_full    (buf_full),
        .ovf         (ovf),
        .rw_stat     (rw_stat),
        .irq         (irq)
    );

endmodule

// File: tb/sim_i2c_tgt.sv
`timescale 1ns/1ps
module sim_i2c_tgt;

    localparam int Q = 10;
    localparam logic [6:0] ADDR = 7'h52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_oe, sda_oe, scl_line, sda_line;
    logic stretch_en = 1'b0, clk_release = 1'b0, buf_rd = 1'b0, tx_wr = 1'b0;
    logic ovf_clr = 1'b0, irq_clr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_byte;
    logic buf_full, ovf, rw_stat, irq;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_tgt u0 (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(ADDR),
        .stretch_en(stretch_en), .clk_release(clk_release), .buf_rd(buf_rd),
        .tx_wr(tx_wr), .tx_data(tx_data), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
        .rx_byte(rx_byte), .buf_full(buf_full), .ovf(ovf), .rw_stat(rw_stat),
        .irq(irq)
    );

    int total = 0, bad = 0, viol = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    // R6: watch for data-line changes by the target while SCL is high
    always @(negedge clk) begin
        if (!rst && prev_scl && scl_line && sda_oe != prev_oe) viol++;
        prev_scl <= scl_line;
        prev_oe  <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1; waitn(1); s = 1'b0; waitn(1);
    endtask

    task automatic clk_pulse(output logic smp);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        waitn(Q / 2);
        smp = sda_line;
        waitn(Q / 2);
        m_scl_low = 1'b1;
        waitn(Q);
    endtask

    task automatic send_bit(input logic b);
        logic d;
        m_sda_low = !b;
        waitn(Q);
        clk_pulse(d);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda_low = 1'b0;
        waitn(Q);
        clk_pulse(s);
        ack = !s;
    endtask

    task automatic read_byte(output logic [7:0] b, input logic give_ack);
        logic s;
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            waitn(Q);
            clk_pulse(s);
            b[i] = s;
        end
        m_sda_low = give_ack;
        waitn(Q);
        clk_pulse(s);
        m_sda_low = 1'b0;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0;
        waitn(Q);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        waitn(Q);
        m_sda_low = 1'b1;
        waitn(Q);
        m_scl_low = 1'b1;
        waitn(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        waitn(Q);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        waitn(Q);
        m_sda_low = 1'b0;
        waitn(Q);
    endtask

    task automatic host_clear();
        strobe(buf_rd); strobe(irq_clr); strobe(ovf_clr);
    endtask

    task automatic t_reset();
        check(scl_oe == 0 && sda_oe == 0, "R11 lines released", {scl_oe, sda_oe}, 0);
        check(irq == 0 && buf_full == 0 && ovf == 0 && rw_stat == 0,
              "R11 flags clear", {irq, buf_full, ovf, rw_stat}, 0);
    endtask

    task automatic t_receive();
        logic ack;
        bus_start();
        write_byte({ADDR, 1'b0}, ack);
        check(ack, "R1 address ack", ack, 1);
        check(rw_stat == 0, "R1 rw_stat", rw_stat, 0);
        check(rx_byte == {ADDR, 1'b0} && buf_full, "R1 buffer load", rx_byte, {ADDR, 1'b0});
        check(irq == 1, "R4 irq on address", irq, 1);
        waitn(40);
        check(scl_oe == 0, "R5 no stretch when disabled", scl_oe, 0);
        strobe(buf_rd);
        check(buf_full == 0, "R10 buf_rd clears full", buf_full, 0);
        strobe(irq_clr);
        waitn(5);
        check(irq == 0, "R4 irq cleared", irq, 0);
        write_byte(8'h3C, ack);
        check(ack && rx_byte == 8'h3C, "R1 data byte", rx_byte, 8'h3C);
        check(irq == 1, "R4 irq on data", irq, 1);
        write_byte(8'hC1, ack);
        check(!ack, "R3 nack when full", ack, 0);
        check(rx_byte == 8'h3C && ovf == 1, "R3 buffer kept, ovf set", {ovf, rx_byte}, {1'b1, 8'h3C});
        write_byte(8'h00, ack);
        check(!ack, "R3 idle after overflow", ack, 0);
        bus_stop();
        strobe(ovf_clr);
        check(ovf == 0, "R10 ovf_clr", ovf, 0);
        host_clear();
    endtask

    task automatic t_nomatch();
        logic ack;
        bus_start();
        write_byte({7'h13, 1'b0}, ack);
        check(!ack, "R9 no ack on other address", ack, 0);
        check(irq == 0 && buf_full == 0, "R9 no irq or load", {irq, buf_full}, 0);
        write_byte({ADDR, 1'b0}, ack);
        check(!ack, "R9 idle until start", ack, 0);
        bus_stop();
    endtask

    task automatic t_stretch_rx();
        logic ack;
        stretch_en = 1'b1;
        bus_start();
        write_byte({ADDR, 1'b0}, ack);
        waitn(40);
        check(ack && scl_oe == 1, "R5 hold after address", scl_oe, 1);
        host_clear();
        strobe(clk_release);
        check(scl_oe == 0, "R5 released", scl_oe, 0);
        write_byte(8'h5A, ack);
        waitn(40);
        check(ack && rx_byte == 8'h5A, "R5 byte after stretch", rx_byte, 8'h5A);
        check(scl_oe == 1, "R5 hold after data", scl_oe, 1);
        strobe(clk_release);
        bus_stop();
        stretch_en = 1'b0;
        host_clear();
    endtask

    task automatic t_transmit();
        logic ack;
        logic [7:0] b;
        bus_start();
        write_byte({ADDR, 1'b1}, ack);
        waitn(40);
        check(ack && rw_stat == 1, "R2 read address ack", rw_stat, 1);
        check(rx_byte == {ADDR, 1'b1}, "R2 address in buffer", rx_byte, {ADDR, 1'b1});
        check(scl_oe == 1, "R2 forced stretch", scl_oe, 1);
        host_clear();
        tx_data = 8'hC3; strobe(tx_wr);
        strobe(clk_release);
        read_byte(b, 1'b1);
        check(b == 8'hC3, "R6 first byte", b, 8'hC3);
        waitn(40);
        check(irq == 1 && scl_oe == 1, "R7 ack leads to stretch", {irq, scl_oe}, 2'b11);
        strobe(irq_clr);
        tx_data = 8'h96; strobe(tx_wr);
        strobe(clk_release);
        read_byte(b, 1'b0);
        check(b == 8'h96, "R6 second byte", b, 8'h96);
        waitn(5);
        check(rw_stat == 0 && scl_oe == 0 && sda_oe == 0, "R7 nack resets",
              {rw_stat, scl_oe, sda_oe}, 0);
        write_byte({ADDR, 1'b0}, ack);
        check(!ack, "R7 idle after nack", ack, 0);
        bus_stop();
        host_clear();
        check(viol == 0, "R6 sda steady while scl high", viol, 0);
    endtask

    task automatic t_restart();
        logic ack;
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        write_byte({ADDR, 1'b0}, ack);
        check(ack && rx_byte == {ADDR, 1'b0}, "R8 start aborts byte", rx_byte, {ADDR, 1'b0});
        bus_stop();
        host_clear();
        m_sda_low = 1'b0;
        waitn(Q);
        m_scl_low = 1'b1;
        waitn(Q);
        write_byte({ADDR, 1'b0}, ack);
        check(!ack, "R8 idle after stop", ack, 0);
        m_scl_low = 1'b0;
        waitn(Q);
    endtask

    initial begin
        waitn(5);
        rst = 1'b0;
        waitn(5);
        t_reset();
        t_receive();
        t_nomatch();
        t_stretch_rx();
        t_transmit();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule